// File: doc/BRIEF.md
# Ten-Cycle Trit Pattern Matcher

This block sits after a per-cycle amplitude slicer in a time-code receiver. Each carrier cycle the slicer delivers one decision, high or low, with a one-clock strobe. The matcher groups these decisions into ten-cycle symbol periods. It classifies each period as one of three pulse-width symbols: a zero (short high pulse), a one (medium pulse) or a position marker (long pulse).

The block does not count the pulse width against thresholds. It compares the ten-cycle window against three fixed templates and counts, for each template, how many positions agree. The template with the most agreement wins. A single corrupted cycle therefore usually still produces the right symbol. A frame-start flag rises on a marker that directly follows another marker.

The controller has three states:
- `ST_FILL` collects the first window of decisions.
- `ST_HUNT` slides the window one cycle at a time until its oldest decision is high and the one before it was low. This transition is called "align".
- `ST_TRACK` issues one symbol every tenth cycle strobe and keeps doing so until reset.

The transitions are:
- "full": from `ST_FILL` to `ST_HUNT`.
- "align": from `ST_HUNT` to `ST_TRACK`.
- "slot": the self-loop in `ST_TRACK` that fires a decision.

Top module: `trit_matcher`

## Requirements
- R1: While reset is asserted and after it is released, `sym_stb` and `frame_start` are 0, `sym_code` is 00 and `sym_score` is 0, until the first symbol is issued.
- R2: No symbol is issued before alignment. Alignment needs ten decisions already held. It happens on the cycle strobe after which the oldest window position is high and the decision just before it was low. That same strobe's window is decided, with `sym_stb` high one clock later.
- R3: Once aligned, `sym_stb` pulses for exactly one clock, one clock after every tenth cycle strobe, and never at any other time.
- R4: A window in time order of 2 high then 8 low yields `sym_code` 00 with score 10. An all-low window yields 00 with score 8.
- R5: A window of 5 high then 5 low yields `sym_code` 01 with score 10.
- R6: A window of 8 high then 2 low yields `sym_code` 10 with score 10.
- R7: The window high, high, low, high, high, then five low decodes as 01 with score 9, not as a zero. An all-high window decodes as 10 with score 8.
- R8: `sym_score` is the largest agreement count. On a tie the order is marker, then one, then zero. For example, the window high, high, low, low, low, high, high, high, low, low gives 10 with score 7.
- R9: `frame_start` pulses together with `sym_stb` only when the issued symbol is a marker and the previously issued symbol was also a marker. The first symbol after reset never raises it.
- R10: `cyc_bit` is ignored on clocks without `cyc_stb`. Idle clocks between strobes, with any bit value, do not change the decoded symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_stb | input | 1 | One-clock strobe, one per carrier cycle |
| cyc_bit | input | 1 | Slicer decision for this cycle (1 = high amplitude) |
| sym_stb | output | 1 | One-clock pulse when a symbol is issued |
| sym_code | output | 2 | 00 zero, 01 one, 10 position marker |
| sym_score | output | $clog2(CYC_PER_SYM+1) | Agreement count of the chosen template |
| frame_start | output | 1 | Marker that follows a marker |

## Verification
The bench uses the default parameters: a ten-cycle period with high counts of 2, 5 and 8. These make the zero and marker templates differ in six positions and each differ from the one template in three. Windows that sit at equal distance from zero and marker therefore exist, so the tie order becomes observable, alongside the single-glitch window. A window fills in only ten strobes, so alignment can be exercised twice, across a second reset, with short runs.

// File: rtl/trit_pkg.sv
package trit_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_MARK = 2'b10
    } sym_e;

    typedef enum logic [1:0] {
        ST_FILL  = 2'b00,
        ST_HUNT  = 2'b01,
        ST_TRACK = 2'b10
    } mstate_e;

endpackage

// File: rtl/trit_scorer.sv
// Agreement count between the window and a template whose first HI cycles are high.
module trit_scorer #(
    parameter int N  = 10,
    parameter int HI = 2,
    parameter int SW = 4
) (
    input  logic [N-1:0]  win,
    output logic [SW-1:0] score
);
    logic [N-1:0] agree;

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam logic REF = (i < HI);
        assign agree[i] = ~(win[i] ^ REF);
    end

    always_comb begin
        score = '0;
        for (int i = 0; i < N; i++) begin
            score = score + SW'(agree[i]);
        end
    end
endmodule

// File: rtl/trit_picker.sv
// Best template; ties go marker, then one, then zero.
module trit_picker
    import trit_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic [SW-1:0] s_zero,
    input  logic [SW-1:0] s_one,
    input  logic [SW-1:0] s_mark,
    output sym_e          code,
    output logic [SW-1:0] best
);
    always_comb begin
        if (s_mark >= s_one && s_mark >= s_zero) begin
            code = SYM_MARK;
            best = s_mark;
        end else if (s_one >= s_zero) begin
            code = SYM_ONE;
            best = s_one;
        end else begin
            code = SYM_ZERO;
            best = s_zero;
        end
    end
endmodule

// File: rtl/trit_matcher.sv
module trit_matcher
    import trit_pkg::*;
#(
    parameter int CYC_PER_SYM = 10,
    parameter int ZERO_HI     = 2,
    parameter int ONE_HI      = 5,
    parameter int MARK_HI     = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cyc_stb,
    input  logic                                 cyc_bit,
    output logic                                 sym_stb,
    output logic [1:0]                           sym_code,
    output logic [$clog2(CYC_PER_SYM+1)-1:0]     sym_score,
    output logic                                 frame_start
);
    localparam int N  = CYC_PER_SYM;
    localparam int SW = $clog2(N + 1);
    localparam int CW = $clog2(N);

    // win_q[0] holds the oldest decision, win_q[N-1] the newest.
    mstate_e       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [N-1:0]  win_q, win_next;
    logic          decide, lead_edge, last_slot, prev_mark;
    logic [SW-1:0] scores [3];
    sym_e          pick_code;
    logic [SW-1:0] pick_score;

    assign win_next  = {cyc_bit, win_q[N-1:1]};
    assign lead_edge = win_q[1] & ~win_q[0];
    assign last_slot = (cnt_q == CW'(N - 1));

    for (genvar k = 0; k < 3; k++) begin : g_ref
        localparam int HI_K = (k == 0) ? ZERO_HI : (k == 1) ? ONE_HI : MARK_HI;
        trit_scorer #(.N(N), .HI(HI_K), .SW(SW)) u_score (
            .win   (win_next),
            .score (scores[k])
        );
    end

    trit_picker #(.SW(SW)) u_pick (
        .s_zero (scores[0]),
        .s_one  (scores[1]),
        .s_mark (scores[2]),
        .code   (pick_code),
        .best   (pick_score)
    );

    // Next state: full, align, slot.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        decide  = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (cyc_stb) begin
                    if (last_slot) begin
                        state_d = ST_HUNT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HUNT: begin
                if (cyc_stb && lead_edge) begin
                    state_d = ST_TRACK;
                    cnt_d   = '0;
                    decide  = 1'b1;
                end
            end
            ST_TRACK: begin
                if (cyc_stb) begin
                    if (last_slot) begin
                        cnt_d  = '0;
                        decide = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (cyc_stb) begin
                win_q <= win_next;
            end
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_stb     <= 1'b0;
            sym_code    <= SYM_ZERO;
            sym_score   <= '0;
            frame_start <= 1'b0;
            prev_mark   <= 1'b0;
        end else begin
            sym_stb     <= decide;
            frame_start <= 1'b0;
            if (decide) begin
                sym_code    <= pick_code;
                sym_score   <= pick_score;
                frame_start <= prev_mark && (pick_code == SYM_MARK);
                prev_mark   <= (pick_code == SYM_MARK);
            end
        end
    end

    p_sym_in_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |-> state_q == ST_TRACK);

    p_sym_after_cyc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |-> $past(cyc_stb));

    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TRACK |-> cnt_q <= CW'(N - 1));

    p_pick_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> (pick_score >= scores[0] && pick_score >= scores[1] && pick_score >= scores[2]));

    p_frame_is_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (sym_stb && sym_code == 2'(SYM_MARK)));

    p_window_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> $stable(win_q));

endmodule

// File: tb/tb_trit_matcher.sv
module tb_trit_matcher;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       cyc_bit = 1'b0;
    logic       sym_stb;
    logic [1:0] sym_code;
    logic [3:0] sym_score;
    logic       frame_start;

    always #10 clk = ~clk;

    trit_matcher dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .cyc_bit     (cyc_bit),
        .sym_stb     (sym_stb),
        .sym_code    (sym_code),
        .sym_score   (sym_score),
        .frame_start (frame_start)
    );

    typedef struct {
        logic [1:0] code;
        int         score;
        bit         frame;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   stb_total = 0;
    int   last_total = 0;
    bit   have_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Counts accepted cycle strobes.
    always @(posedge clk) begin
        if (!rst_n) stb_total <= 0;
        else if (cyc_stb) stb_total <= stb_total + 1;
    end

    // Monitor: pop and compare each issued symbol.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_prev = 1'b0;
        end else if (sym_stb) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2/R3", "unexpected sym_stb", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(sym_code == e.code, e.tag, "sym_code", int'(sym_code), int'(e.code));
                chk(int'(sym_score) == e.score, e.tag, "sym_score", int'(sym_score), e.score);
                chk(frame_start == e.frame, e.tag, "frame_start", int'(frame_start), int'(e.frame));
                if (have_prev)
                    chk(stb_total - last_total == 10, "R3", "strobes per symbol", stb_total - last_total, 10);
                last_total = stb_total;
                have_prev  = 1'b1;
            end
        end
    end

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        cyc_stb = 1'b1;
        cyc_bit = b;
        @(negedge clk);
        cyc_stb = 1'b0;
        cyc_bit = ~b;
        repeat (gap) @(negedge clk);
    endtask

    // p[0] is sent first.
    task automatic send_sym(input logic [9:0] p, input int gap, input logic [1:0] code,
                            input int score, input bit frame, input string tag);
        q.push_back('{code, score, frame, tag});
        for (int i = 0; i < 10; i++) send_bit(p[i], gap);
    endtask

    function automatic logic [9:0] hi_first(input int h);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = (i < h);
        return r;
    endfunction

    task automatic reset_checks();
        chk(sym_stb == 1'b0, "R1", "sym_stb in reset", int'(sym_stb), 0);
        chk(frame_start == 1'b0, "R1", "frame_start in reset", int'(frame_start), 0);
        chk(sym_code == 2'b00, "R1", "sym_code in reset", int'(sym_code), 0);
        chk(sym_score == 4'd0, "R1", "sym_score in reset", int'(sym_score), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;

        // R2: no symbol while the leading low run fills and hunts.
        repeat (12) send_bit(1'b0, 1);
        send_sym(hi_first(2), 1, 2'b00, 10, 1'b0, "R2/R4");
        send_sym(hi_first(5), 1, 2'b01, 10, 1'b0, "R5");
        send_sym(hi_first(8), 1, 2'b10, 10, 1'b0, "R6");
        send_sym(hi_first(8), 1, 2'b10, 10, 1'b1, "R9");
        // R7: 1,1,0,1,1,0,0,0,0,0 decodes as one.
        send_sym(10'b0000011011, 1, 2'b01, 9, 1'b0, "R7");
        // R8: 1,1,0,0,0,1,1,1,0,0 ties zero and marker at 7.
        send_sym(10'b0011100011, 1, 2'b10, 7, 1'b0, "R8");
        // R8: 1,1,1,0,0,1,1,0,0,0 ties zero and marker at 7; follows a marker.
        send_sym(10'b0001100111, 1, 2'b10, 7, 1'b1, "R8/R9");
        // R10: long idle gaps with inverted bit between strobes.
        send_sym(hi_first(8), 6, 2'b10, 10, 1'b1, "R10");
        send_sym(hi_first(2), 1, 2'b00, 10, 1'b0, "R4");
        send_sym(hi_first(8), 1, 2'b10, 10, 1'b0, "R9");
        send_sym(hi_first(0), 1, 2'b00, 8, 1'b0, "R4");
        send_sym(hi_first(10), 1, 2'b10, 8, 1'b0, "R7");
        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R3", "symbols not issued", q.size(), 0);

        // Second reset and fresh alignment.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        repeat (5) send_bit(1'b0, 1);
        send_sym(hi_first(8), 2, 2'b10, 10, 1'b0, "R2/R9");
        send_sym(hi_first(8), 2, 2'b10, 10, 1'b1, "R9");
        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R3", "symbols not issued", q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule